// File: doc/BRIEF.md
# CAN Bus Join and Bus-Off Recovery Sequencer

This block decides when a CAN node may take part in bus traffic. It counts runs of eleven consecutive recessive (logic 1) bits in the sampled receive stream. A bit is examined only in a cycle where the bit-sample strobe is high. When software releases the initialization input, one such run must pass before the node is reported active. The same applies after software takes the node back into initialization while it is active.

A one-cycle bus-off pulse takes the node off the bus and starts recovery at once, with no software step. Recovery ends after 128 separate runs. The receive error counter shows how many runs have been seen so far. At the end, the node joins traffic straight away if the initialization input is low. If that input is still high, the node waits for it to go low and then for one further run.

The block also holds the transmit and receive error counters. Software may load them only while the configuration-change enable is high. All pins are plain control and status signals. No pin carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `can_bus_join`

## Requirements
- R1: After reset, node_active is 0, recov_done is 0 and tec_cnt and rec_cnt are both 0. The block is in the initialization state.
- R2: After sw_init goes low, eleven strobed samples of rx_bit = 1 make node_active 1, seen after the clock edge of the eleventh sample. Cycles with bit_strobe = 0 are not counted, whatever rx_bit holds.
- R3: A strobed sample of rx_bit = 0 sets the current run length back to zero. A full run of eleven recessive samples is then needed again.
- R4: A busoff_pulse while the node is active makes node_active 0 on the next cycle and clears rec_cnt to 0. Run counting then begins without any other input.
- R5: During recovery, rec_cnt goes up by exactly one for each completed run of eleven recessive samples. Runs do not overlap, and a dominant sample discards a partial run.
- R6: When the 128th run completes, recov_done is 1 for exactly one cycle. If sw_init is 0 at that point, node_active becomes 1 in the same cycle and tec_cnt and rec_cnt read 0.
- R7: If sw_init is 1 when the 128th run completes, node_active stays 0 and rec_cnt holds 128. Runs seen while sw_init stays 1 do not activate the node. After sw_init goes low, one more run of eleven makes the node active.
- R8: Setting sw_init while the node is active makes node_active 0 on the next cycle. After sw_init goes low again, a fresh run of eleven is required.
- R9: A write with wr_tec or wr_rec loads wr_data into that counter only when cfg_en is 1. With cfg_en = 0 the counter is left unchanged. Writes to rec_cnt are also ignored during bus-off recovery.
- R10: Whenever node_active rises, tec_cnt and rec_cnt are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe | input | 1 | High for one cycle when rx_bit holds a new bus sample |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| sw_init | input | 1 | Software initialization request, 1 = hold the node off the bus |
| busoff_pulse | input | 1 | One-cycle pulse on entry to bus-off |
| cfg_en | input | 1 | Configuration-change enable for counter writes |
| wr_tec | input | 1 | Write strobe for the transmit error counter |
| wr_rec | input | 1 | Write strobe for the receive error counter |
| wr_data | input | ERR_W | Value to load on a write |
| node_active | output | 1 | Node takes part in bus traffic |
| tec_cnt | output | ERR_W | Transmit error counter |
| rec_cnt | output | ERR_W | Receive error counter, shows recovery progress during bus-off |
| recov_done | output | 1 | One-cycle pulse when the final recovery run is seen |

## Verification
The run detector is tested with clean recessive sequences of every length from one to eleven, with idle non-strobe dominant cycles between them. This separates strobe gating from the counting itself. A single dominant sample is then placed at each of the eleven run positions, which shows whether a partial run really restarts from zero. Two full recoveries are driven. The first has the initialization input low and periodic partial runs cut short by a dominant bit, so it checks the per-run increments and joining at once. The second has the initialization input high and confirms the hold at 128 and the extra run needed afterwards. Counter writes are tried with the enable both off and on, and during recovery.

// File: rtl/can_join_pkg.sv
package can_join_pkg;
  typedef enum logic [2:0] {
    JS_INIT   = 3'd0,
    JS_INTEG  = 3'd1,
    JS_ACTIVE = 3'd2,
    JS_BUSOFF = 3'd3,
    JS_HOLD   = 3'd4
  } join_state_t;
endpackage

// File: rtl/can_run_detect.sv
module can_run_detect #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobe,
  input  logic rx,
  output logic run_hit
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

  logic [RW-1:0] len_q;

  // a run completes on the strobed recessive sample that fills it
  assign run_hit = strobe && rx && !clr && (len_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (clr) begin
      len_q <= '0;
    end else if (strobe) begin
      if (!rx || run_hit) begin
        len_q <= '0;
      end else begin
        len_q <= len_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_join_fsm.sv
module can_join_fsm
  import can_join_pkg::*;
#(
  parameter int ERR_W      = 8,
  parameter int RECOV_RUNS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_init,
  input  logic             busoff_pulse,
  input  logic             run_hit,
  input  logic [ERR_W-1:0] rec_val,
  output logic             det_clr,
  output logic             go_active,
  output logic             busoff_entry,
  output logic             rec_inc,
  output logic             rec_lock,
  output logic             node_active,
  output logic             recov_done
);
  localparam logic [ERR_W-1:0] LAST_RUN = ERR_W'(RECOV_RUNS - 1);

  join_state_t st_q, st_d;
  logic        last_run;
  logic        done_q;

  assign last_run = run_hit && (rec_val == LAST_RUN);

  always_comb begin
    st_d = st_q;
    case (st_q)
      JS_INIT:   if (!sw_init) st_d = JS_INTEG;
      JS_INTEG: begin
        if (sw_init)      st_d = JS_INIT;
        else if (run_hit) st_d = JS_ACTIVE;
      end
      JS_ACTIVE: if (sw_init) st_d = JS_INIT;
      JS_BUSOFF: begin
        if (last_run) st_d = sw_init ? JS_HOLD : JS_ACTIVE;
      end
      JS_HOLD:   if (!sw_init) st_d = JS_INTEG;
      default:   st_d = JS_INIT;
    endcase
    // bus-off entry overrides every other request
    if (busoff_pulse && (st_q != JS_BUSOFF)) st_d = JS_BUSOFF;
  end

  assign det_clr      = !((st_q == JS_INTEG) || (st_q == JS_BUSOFF));
  assign go_active    = (st_d == JS_ACTIVE) && (st_q != JS_ACTIVE);
  assign busoff_entry = (st_d == JS_BUSOFF) && (st_q != JS_BUSOFF);
  assign rec_inc      = (st_q == JS_BUSOFF) && run_hit;
  assign rec_lock     = (st_q == JS_BUSOFF);
  assign node_active  = (st_q == JS_ACTIVE);
  assign recov_done   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= JS_INIT;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == JS_BUSOFF) && last_run;
    end
  end
endmodule

// File: rtl/can_err_cnt.sv
module can_err_cnt #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             rec_clr,
  input  logic             rec_inc,
  input  logic             rec_lock,
  input  logic             cfg_en,
  input  logic             wr_tec,
  input  logic             wr_rec,
  input  logic [ERR_W-1:0] wr_data,
  output logic [ERR_W-1:0] tec,
  output logic [ERR_W-1:0] rec
);
  logic tec_we, rec_we;

  assign tec_we = cfg_en && wr_tec;
  assign rec_we = cfg_en && wr_rec && !rec_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tec <= '0;
    end else if (clr_all) begin
      tec <= '0;
    end else if (tec_we) begin
      tec <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec <= '0;
    end else if (clr_all || rec_clr) begin
      rec <= '0;
    end else if (rec_inc) begin
      rec <= rec + 1'b1;
    end else if (rec_we) begin
      rec <= wr_data;
    end
  end
endmodule

// File: rtl/can_bus_join.sv
module can_bus_join #(
  parameter int RUN_LEN    = 11,
  parameter int RECOV_RUNS = 128,
  parameter int ERR_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_strobe,
  input  logic             rx_bit,
  input  logic             sw_init,
  input  logic             busoff_pulse,
  input  logic             cfg_en,
  input  logic             wr_tec,
  input  logic             wr_rec,
  input  logic [ERR_W-1:0] wr_data,
  output logic             node_active,
  output logic [ERR_W-1:0] tec_cnt,
  output logic [ERR_W-1:0] rec_cnt,
  output logic             recov_done
);
  logic det_clr, run_hit, go_active, busoff_entry, rec_inc, rec_lock;

  can_run_detect #(.RUN_LEN(RUN_LEN)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (det_clr),
    .strobe  (bit_strobe),
    .rx      (rx_bit),
    .run_hit (run_hit)
  );

  can_join_fsm #(.ERR_W(ERR_W), .RECOV_RUNS(RECOV_RUNS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_init      (sw_init),
    .busoff_pulse (busoff_pulse),
    .run_hit      (run_hit),
    .rec_val      (rec_cnt),
    .det_clr      (det_clr),
    .go_active    (go_active),
    .busoff_entry (busoff_entry),
    .rec_inc      (rec_inc),
    .rec_lock     (rec_lock),
    .node_active  (node_active),
    .recov_done   (recov_done)
  );

  can_err_cnt #(.ERR_W(ERR_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (go_active),
    .rec_clr  (busoff_entry),
    .rec_inc  (rec_inc),
    .rec_lock (rec_lock),
    .cfg_en   (cfg_en),
    .wr_tec   (wr_tec),
    .wr_rec   (wr_rec),
    .wr_data  (wr_data),
    .tec      (tec_cnt),
    .rec      (rec_cnt)
  );
endmodule

// File: rtl/can_bus_join_chk.sv
module can_bus_join_chk #(
  parameter int ERR_W      = 8,
  parameter int RECOV_RUNS = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_strobe,
  input logic             rx_bit,
  input logic             sw_init,
  input logic             busoff_pulse,
  input logic             cfg_en,
  input logic             wr_tec,
  input logic             node_active,
  input logic [ERR_W-1:0] tec_cnt,
  input logic [ERR_W-1:0] rec_cnt,
  input logic             recov_done
);
  // R2
  join_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(node_active) |-> $past(bit_strobe && rx_bit));

  // R4
  busoff_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_pulse && node_active) |=> (!node_active && rec_cnt == '0));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done |=> !recov_done);

  // R7
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recov_done && !node_active) |-> (rec_cnt == ERR_W'(RECOV_RUNS)));

  // R8
  init_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_active && sw_init) |=> !node_active);

  // R9
  tec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tec_cnt != $past(tec_cnt)) |-> ($past(cfg_en && wr_tec) || $rose(node_active)));

  // R10
  join_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(node_active) |-> (tec_cnt == '0 && rec_cnt == '0));
endmodule

bind can_bus_join can_bus_join_chk #(.ERR_W(ERR_W), .RECOV_RUNS(RECOV_RUNS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_strobe   (bit_strobe),
  .rx_bit       (rx_bit),
  .sw_init      (sw_init),
  .busoff_pulse (busoff_pulse),
  .cfg_en       (cfg_en),
  .wr_tec       (wr_tec),
  .node_active  (node_active),
  .tec_cnt      (tec_cnt),
  .rec_cnt      (rec_cnt),
  .recov_done   (recov_done)
);

// File: tb/can_bus_join_tb.sv
module can_bus_join_tb;
  localparam int RUN_LEN    = 11;
  localparam int RECOV_RUNS = 128;
  localparam int ERR_W      = 8;
  localparam int WDOG       = 100000;

  logic clk = 1'b0;
  logic rst_n, bit_strobe, rx_bit, sw_init, busoff_pulse, cfg_en, wr_tec, wr_rec;
  logic [ERR_W-1:0] wr_data;
  logic node_active, recov_done;
  logic [ERR_W-1:0] tec_cnt, rec_cnt;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  can_bus_join #(.RUN_LEN(RUN_LEN), .RECOV_RUNS(RECOV_RUNS), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
    .sw_init(sw_init), .busoff_pulse(busoff_pulse), .cfg_en(cfg_en),
    .wr_tec(wr_tec), .wr_rec(wr_rec), .wr_data(wr_data),
    .node_active(node_active), .tec_cnt(tec_cnt), .rec_cnt(rec_cnt),
    .recov_done(recov_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog R1..: cycles %0d expected below %0d", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors = vectors + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: inputs set here, outputs read at the following falling edge
  task automatic step(input logic s, input logic r);
    bit_strobe = s;
    rx_bit     = r;
    @(negedge clk);
    bit_strobe = 1'b0;
    rx_bit     = 1'b0;
  endtask

  task automatic recs(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1);
  endtask

  task automatic wr(input logic en, input logic t, input logic r, input int d);
    cfg_en  = en;
    wr_tec  = t;
    wr_rec  = r;
    wr_data = ERR_W'(d);
    step(1'b0, 1'b0);
    cfg_en  = 1'b0;
    wr_tec  = 1'b0;
    wr_rec  = 1'b0;
  endtask

  task automatic reinit();
    sw_init = 1'b1;
    step(1'b0, 1'b0);
    sw_init = 1'b0;
    step(1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; bit_strobe = 1'b0; rx_bit = 1'b0; sw_init = 1'b1;
    busoff_pulse = 1'b0; cfg_en = 1'b0; wr_tec = 1'b0; wr_rec = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 node_active", node_active, 0);
    chk("R1 recov_done", recov_done, 0);
    chk("R1 tec", tec_cnt, 0);
    chk("R1 rec", rec_cnt, 0);

    // R9: write gating in the initialization state
    wr(1'b0, 1'b1, 1'b0, 'h5A);
    chk("R9 tec write blocked", tec_cnt, 0);
    wr(1'b1, 1'b1, 1'b0, 'h5A);
    chk("R9 tec write", tec_cnt, 'h5A);
    wr(1'b1, 1'b0, 1'b1, 'h33);
    chk("R9 rec write", rec_cnt, 'h33);
    wr(1'b0, 1'b0, 1'b1, 'h77);
    chk("R9 rec write blocked", rec_cnt, 'h33);
    chk("R9 tec untouched", tec_cnt, 'h5A);

    // R2: lengths 1..11 with idle dominant non-strobe cycles between samples
    sw_init = 1'b0;
    step(1'b0, 1'b0);
    for (int n = 1; n <= RUN_LEN; n++) begin
      step(1'b0, 1'b0);
      step(1'b1, 1'b1);
      chk($sformatf("R2 active after %0d samples", n), node_active, (n == RUN_LEN) ? 1 : 0);
    end
    chk("R10 tec cleared on join", tec_cnt, 0);
    chk("R10 rec cleared on join", rec_cnt, 0);

    // R8: drop out and rejoin
    sw_init = 1'b1;
    step(1'b0, 1'b0);
    chk("R8 inactive after init", node_active, 0);
    sw_init = 1'b0;
    step(1'b0, 1'b0);
    recs(RUN_LEN - 1);
    chk("R8 no join on short run", node_active, 0);
    recs(1);
    chk("R8 rejoin after full run", node_active, 1);
    reinit();

    // R3: dominant sample at each position of the run
    for (int k = 0; k < RUN_LEN; k++) begin
      recs(k);
      step(1'b1, 1'b0);
      recs(RUN_LEN - 1);
      chk($sformatf("R3 dominant at %0d restarts", k), node_active, 0);
      recs(1);
      chk($sformatf("R3 join after restart %0d", k), node_active, 1);
      reinit();
    end
    recs(RUN_LEN);
    chk("R2 active before bus-off", node_active, 1);

    // R4: enter bus-off from active
    wr(1'b1, 1'b1, 1'b0, 'h21);
    busoff_pulse = 1'b1;
    step(1'b0, 1'b0);
    busoff_pulse = 1'b0;
    chk("R4 inactive on bus-off", node_active, 0);
    chk("R4 rec cleared on bus-off", rec_cnt, 0);
    wr(1'b1, 1'b0, 1'b1, 'h40);
    chk("R9 rec write ignored in recovery", rec_cnt, 0);

    // R5/R6: full recovery with init low, some runs cut short
    for (int i = 1; i <= RECOV_RUNS; i++) begin
      if (i % 3 == 0) begin
        recs(5);
        step(1'b1, 1'b0);
      end
      recs(RUN_LEN - 1);
      chk($sformatf("R5 rec before run %0d", i), rec_cnt, i - 1);
      recs(1);
      if (i < RECOV_RUNS) begin
        chk($sformatf("R5 rec after run %0d", i), rec_cnt, i);
        chk($sformatf("R5 inactive after run %0d", i), node_active, 0);
        chk($sformatf("R6 no done at run %0d", i), recov_done, 0);
      end
    end
    chk("R6 done pulse", recov_done, 1);
    chk("R6 joins at once", node_active, 1);
    chk("R6 rec cleared", rec_cnt, 0);
    chk("R6 tec cleared", tec_cnt, 0);
    step(1'b0, 1'b0);
    chk("R6 done one cycle", recov_done, 0);

    // R7: recovery ends with init still high
    sw_init = 1'b1;
    busoff_pulse = 1'b1;
    step(1'b0, 1'b0);
    busoff_pulse = 1'b0;
    chk("R4 inactive on second bus-off", node_active, 0);
    for (int i = 1; i <= RECOV_RUNS; i++) begin
      recs(RUN_LEN);
      if (i < RECOV_RUNS) chk($sformatf("R5 second rec %0d", i), rec_cnt, i);
    end
    chk("R7 done pulse", recov_done, 1);
    chk("R7 still inactive", node_active, 0);
    chk("R7 rec holds full", rec_cnt, RECOV_RUNS);
    recs(RUN_LEN);
    chk("R7 runs ignored while init high", node_active, 0);
    chk("R7 rec still full", rec_cnt, RECOV_RUNS);
    sw_init = 1'b0;
    step(1'b0, 1'b0);
    recs(RUN_LEN - 1);
    chk("R7 no join before extra run", node_active, 0);
    recs(1);
    chk("R7 join after extra run", node_active, 1);
    chk("R10 rec cleared after hold", rec_cnt, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule